// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block sits on the target side of a two-wire SMBus/I2C bus, on a device that can raise an interrupt by pulling a shared alert line low. A local request latches an alert. The host answers the alert by doing a one-byte read from the alert response broadcast address. Every device that has an alert pending acknowledges that address and sends its own 7-bit address back as the data byte.

Several devices may be alerting at the same moment. Because SDA is open-drain, all of them transmit together and the bus carries the wired-AND of their bytes. Each responder watches the bus bit by bit. A responder that releases the line for a 1 but reads back a 0 has lost. It goes quiet for the rest of the byte and keeps its alert. The device with the numerically lowest address therefore wins. After the host's NACK and STOP, the winner drops its alert. The host repeats the read until the alert line is released.

SCL and SDA are sampled with the faster system clock. Each goes through a synchroniser with edge detection. The block drives only an SDA pull-low enable.

Top module: `smb_alert_responder`

## Requirements
- R1: After a synchronous active-low reset, `alert_o` is 0 and `sda_pull_o` is 0.
- R2: A 0-to-1 transition on `alert_req_i` sets the pending alert, and `alert_o` goes to 1 within a few system clocks. Holding the request high does not set the alert again once it has been cleared.
- R3: An address byte of 0x19 (7-bit address 0x0C with the read bit 1) is acknowledged by pulling SDA low during the ninth clock only while the alert is pending. With no pending alert, SDA stays released for the whole transfer.
- R4: Any other address byte is not acknowledged and leaves the pending alert unchanged. This includes the write form 0x18 and a different address such as 0x1B.
- R5: After acknowledging, the block sends the byte {own_addr_i, 0}, most significant bit first. It drives 0 bits by pulling SDA low and 1 bits by releasing SDA. The pull enable only rises while SCL is low.
- R6: If the block releases SDA for a 1 but samples SDA low while SCL is high, it stops driving for the rest of the byte and keeps its alert. With two responders, the host therefore reads the lower address.
- R7: A responder that sent its full byte without losing clears its alert when the host answers the ninth bit with a NACK (SDA high) and then sends a STOP.
- R8: If the host answers the ninth bit with an ACK (SDA low), the alert stays set after the STOP.
- R9: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) are recognised at any point. A STOP in the middle of an address byte returns the block to idle, and the next transaction is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| own_addr_i | input | 7 | This device's 7-bit bus address |
| alert_req_i | input | 1 | Local alert request; its rising edge latches an alert |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| alert_o | output | 1 | 1 pulls the shared alert line low (alert pending) |

## Verification
A wrong shift or bit count in the address decoder shows up within the ninth SCL clock of the broadcast read: the acknowledge is missing, or it appears for the wrong address. A wrong arbitration flag shows up one data bit after the first differing bit. In that case the host reads a corrupted wired-AND byte instead of the lower address. A win flag that is left stale appears only at the STOP, as an alert that is cleared on the wrong device or never cleared. For that reason, every transaction checks both devices' alert outputs after the STOP.

// File: rtl/smb_ara_pkg.sv
// Shared constants and types for the alert response responder.
// Assumes 7-bit bus addressing; the broadcast address is fixed by the bus.
package smb_ara_pkg;
    localparam int          ADDR_W   = 7;
    localparam int          BYTE_W   = ADDR_W + 1;
    localparam logic [6:0]  ARA_ADDR = 7'h0C;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a START
        ST_ADDR,   // shifting in the address byte
        ST_ACK,    // holding SDA low for the address acknowledge
        ST_SEND,   // returning own address with arbitration
        ST_HACK,   // watching the host's ninth bit
        ST_WAIT    // released, waiting for STOP or START
    } ara_state_e;
endpackage

// File: rtl/ara_line_sync.sv
// Synchronises SCL and SDA into the system clock domain and flags
// SCL edges, START and STOP. Assumes the system clock samples each SCL
// phase several times. Idle bus level (high) is used as the reset value.
module ara_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    // Synchroniser chains: one flop per stage for each line.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // Previous-sample registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edge and bus-condition decode; START/STOP need SCL high on both samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_det, stop_det})); // R9
endmodule

// File: rtl/ara_alert_ctl.sv
// Holds the pending alert. A rising edge of the request sets it and a
// won-and-finished pulse clears it. A set wins over a clear in the same cycle.
module ara_alert_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic clear_i,
    output logic alert_o
);
    logic req_p;
    logic req_edge;

    assign req_edge = req_i & ~req_p;

    // Request edge register and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_p   <= 1'b0;
            alert_o <= 1'b0;
        end else begin
            req_p <= req_i;
            if (req_edge)
                alert_o <= 1'b1;
            else if (clear_i)
                alert_o <= 1'b0;
        end
    end

    AST_CLEAR_ONLY_BY_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_o) |-> $past(clear_i)); // R7
    AST_SET_ONLY_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_o) |-> $past(req_i)); // R2
endmodule

// File: rtl/ara_protocol.sv
// Bus engine for the alert response read. It decodes the address byte,
// acknowledges the broadcast read while an alert is pending, and returns
// {own address, 0} with bitwise arbitration. It signals a win once the host
// has NACKed and sent a STOP. Assumes the synchronised inputs come from
// ara_line_sync and that SCL is not stretched by this device.
module ara_protocol
    import smb_ara_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              pend_i,
    output logic              sda_pull_o,
    output logic              win_done_o
);
    localparam int             CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [BYTE_W-1:0] ARA_RD  = {ARA_ADDR, 1'b1};

    ara_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              won;
    logic              nack_seen;

    // Main sequencer: bus conditions first, then per-state SCL edge handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            won        <= 1'b0;
            nack_seen  <= 1'b0;
            sda_pull_o <= 1'b0;
            win_done_o <= 1'b0;
        end else begin
            win_done_o <= 1'b0;
            if (stop_det) begin
                if (state == ST_WAIT && won && nack_seen)
                    win_done_o <= 1'b1;
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
                won        <= 1'b0;
            end else if (start_det) begin
                state      <= ST_ADDR;
                bit_cnt    <= '0;
                sda_pull_o <= 1'b0;
                won        <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CNT_FULL) begin
                            if (rx_sh == ARA_RD && pend_i) begin
                                state      <= ST_ACK;
                                sda_pull_o <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state      <= ST_SEND;
                            bit_cnt    <= '0;
                            tx_sh      <= {own_addr, 1'b0};
                            won        <= 1'b1;
                            nack_seen  <= 1'b0;
                            sda_pull_o <= ~own_addr[ADDR_W-1];
                        end
                    end
                    ST_SEND: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (won && tx_sh[BYTE_W-1] && !sda_s)
                                won <= 1'b0;
                        end else if (scl_fall) begin
                            if (bit_cnt == CNT_FULL) begin
                                state      <= ST_HACK;
                                sda_pull_o <= 1'b0;
                            end else begin
                                tx_sh      <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_pull_o <= won & ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_HACK: begin
                        if (scl_rise)
                            nack_seen <= sda_s;
                        else if (scl_fall)
                            state <= ST_WAIT;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ACK_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK) |-> pend_i); // R3
    AST_PULL_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s); // R5
    AST_LOSER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && !won) |-> !sda_pull_o); // R6
    AST_WIN_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        win_done_o |-> $past(stop_det)); // R7
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_o); // R4
endmodule

// File: rtl/smb_alert_responder.sv
// Top of the alert response responder: line synchroniser, bus engine and
// alert latch. Assumes the system clock runs several times faster than SCL
// and that the pads turn sda_pull_o and alert_o into open-drain pulls.
module smb_alert_responder
    import smb_ara_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              alert_req_i,
    output logic              sda_pull_o,
    output logic              alert_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic win_done;

    ara_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ara_protocol u_proto (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .own_addr   (own_addr_i),
        .pend_i     (alert_o),
        .sda_pull_o (sda_pull_o),
        .win_done_o (win_done)
    );

    ara_alert_ctl u_alert (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (alert_req_i),
        .clear_i (win_done),
        .alert_o (alert_o)
    );

    AST_NO_PULL_WITHOUT_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> alert_o); // R3
endmodule

// File: tb/tb_smb_alert_responder.sv
// Two responders share one open-drain SDA line driven by a bench host.
module tb_smb_alert_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic [6:0] addr_a = 7'h00;
    logic [6:0] addr_b = 7'h7F;
    logic       req_a = 1'b0;
    logic       req_b = 1'b0;
    logic       pull_a, pull_b, alert_a, alert_b;
    logic       sda_bus;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    assign sda_bus = sda_h & ~pull_a & ~pull_b;

    smb_alert_responder dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
        .own_addr_i(addr_a), .alert_req_i(req_a),
        .sda_pull_o(pull_a), .alert_o(alert_a));

    smb_alert_responder dut_peer (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
        .own_addr_i(addr_b), .alert_req_i(req_b),
        .sda_pull_o(pull_b), .alert_o(alert_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_start();
        sda_h = 1'b1; scl_h = 1'b1; wt(8);
        sda_h = 1'b0; wt(8);
        scl_h = 1'b0;
    endtask

    task automatic host_stop();
        wt(4); sda_h = 1'b0; wt(4);
        scl_h = 1'b1; wt(8);
        sda_h = 1'b1; wt(8);
    endtask

    task automatic put_bit(input logic b);
        wt(4); sda_h = b; wt(4);
        scl_h = 1'b1; wt(8);
        scl_h = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wt(4); sda_h = 1'b1; wt(4);
        scl_h = 1'b1; wt(4);
        b = sda_bus; wt(4);
        scl_h = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] abyte, input logic host_ack,
                        output logic ack, output logic [7:0] data);
        logic b;
        host_start();
        for (int i = 7; i >= 0; i--) put_bit(abyte[i]);
        get_bit(ack);
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            data[i] = b;
        end
        put_bit(host_ack ? 1'b0 : 1'b1);
        host_stop();
        wt(6);
    endtask

    task automatic pulse(input bit a, input bit b);
        req_a = a; req_b = b; wt(2);
        req_a = 1'b0; req_b = 1'b0; wt(4);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            chk(0, "WATCHDOG", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic       ack;
        logic [7:0] d;
        logic [6:0] lo, hi;
        wt(5);
        rst_n = 1'b1;
        wt(2);
        // R1: reset state
        chk(alert_a == 0 && pull_a == 0, "R1", {alert_a, pull_a}, 0);

        // R3: no alert pending, broadcast read gets no ack and an idle bus
        xfer(8'h19, 1'b0, ack, d);
        chk(ack == 1'b1, "R3 no-pending ack", ack, 1);
        chk(d == 8'hFF, "R3 no-pending data", d, 8'hFF);

        // R2: rising request sets alert; holding high does not re-set
        addr_a = 7'h2A;
        req_a = 1'b1; wt(6);
        chk(alert_a == 1, "R2 set", alert_a, 1);
        // R4: other address and write form are not acknowledged
        xfer(8'h1B, 1'b0, ack, d);
        chk(ack == 1'b1 && alert_a == 1, "R4 other addr", {ack, alert_a}, 3);
        xfer(8'h18, 1'b0, ack, d);
        chk(ack == 1'b1 && alert_a == 1, "R4 write form", {ack, alert_a}, 3);
        // R8: host ACK keeps the alert
        xfer(8'h19, 1'b1, ack, d);
        chk(d == {7'h2A, 1'b0}, "R8 data", d, {7'h2A, 1'b0});
        chk(alert_a == 1, "R8 alert kept", alert_a, 1);
        // R9: STOP inside address byte, then a full read works
        host_start();
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
        host_stop();
        xfer(8'h19, 1'b0, ack, d);
        chk(ack == 1'b0 && d == {7'h2A, 1'b0}, "R9 after abort", {ack, d}, {1'b0, 7'h2A, 1'b0});
        chk(alert_a == 0, "R7 cleared", alert_a, 0);
        wt(10);
        chk(alert_a == 0, "R2 level held no re-set", alert_a, 0);
        req_a = 1'b0; wt(4);

        // R5 R7: every own address, single responder
        for (int a = 0; a < 128; a++) begin
            addr_a = 7'(a);
            pulse(1'b1, 1'b0);
            xfer(8'h19, 1'b0, ack, d);
            chk(ack == 1'b0, "R3 ack", ack, 0);
            chk(d == {7'(a), 1'b0}, "R5 data", d, {7'(a), 1'b0});
            chk(alert_a == 0 && alert_b == 0, "R7 clear", {alert_a, alert_b}, 0);
        end

        // R6 R7: two responders, differing in one bit position
        for (int i = 0; i < 32; i++) begin
            addr_a = 7'(i * 4 + 1);
            addr_b = addr_a ^ (7'd1 << (i % 7));
            lo = (addr_a < addr_b) ? addr_a : addr_b;
            hi = (addr_a < addr_b) ? addr_b : addr_a;
            pulse(1'b1, 1'b1);
            xfer(8'h19, 1'b0, ack, d);
            chk(d == {lo, 1'b0}, "R6 winner data", d, {lo, 1'b0});
            chk((addr_a == lo) ? (alert_a == 0 && alert_b == 1) : (alert_a == 1 && alert_b == 0),
                "R6 loser keeps alert", {alert_a, alert_b}, (addr_a == lo) ? 1 : 2);
            xfer(8'h19, 1'b0, ack, d);
            chk(d == {hi, 1'b0}, "R6 second data", d, {hi, 1'b0});
            chk(alert_a == 0 && alert_b == 0, "R7 both clear", {alert_a, alert_b}, 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule